// File: doc/BRIEF.md
# Compare-Value Timer With Offset

This block is one timer channel. It watches a shared 64-bit count that always counts up, and it raises a level interrupt when that count reaches a programmed limit. A 64-bit offset register is subtracted from the incoming count to give the channel's own virtual count. With the offset at zero the channel behaves as a physical timer. With a nonzero offset the same logic serves as a virtual timer.

Software programs the limit in one of two ways. It can write the absolute 64-bit compare value directly. It can also write a signed 32-bit remaining-time value, which the block adds to the present virtual count. Reads of the remaining-time view return the compare value minus the virtual count, truncated to 32 bits. The firing condition is combinational on the stored registers and the live count, so it is re-evaluated as soon as any write to control, compare or offset lands. The interrupt output is a registered copy of the unmasked condition.

Registers are written through a single-cycle write strobe with a 3-bit select. They are read through a combinational select-to-data path.

Top module: `cvt_timer`

## Requirements
- R1: While `rst` is high on a clock edge, control, compare and offset are cleared to 0. `irq` is 0 on the edge after reset.
- R2: The virtual count is `phys_count - offset` modulo 2^64. It is read with select 4.
- R3: Control (select 0) reads bit 0 as enable, bit 1 as mask and bit 2 as status. Bits 63:3 read as 0. Status is 1 exactly when enable is 1 and the virtual count is unsigned greater than or equal to compare.
- R4: `irq` is 1 on the edge after a cycle in which status was 1 and mask was 0, and 0 otherwise. This means a masked or disabled channel never interrupts.
- R5: Select 1 writes and reads the full 64-bit compare value. Without a write to select 1 or 2, compare holds its value.
- R6: A read of select 2 returns `(compare - virtual count)` truncated to bits 31:0, with bits 63:32 reading as 0.
- R7: A write to select 2 sets compare to the virtual count of the write cycle plus `wr_data[31:0]` sign-extended to 64 bits.
- R8: A write to select 0 stores only `wr_data[1:0]`. A value written to bit 2 or above has no effect on what control reads back.
- R9: Select 3 writes and reads the offset. A change of offset changes status in the cycle after the write, with no other access needed.
- R10: Selects 5 to 7 read as 0, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phys_count | input | 64 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 64 | Read data, combinational |
| irq | output | 1 | Level interrupt, registered |

## Verification
Two things can happen in the same cycle: a remaining-time write that samples the virtual count, and an advance of the shared count at that same edge. The bench drives the write together with a count value. It moves the count right after the edge and expects compare to be based on the pre-edge count. A compare write in the same cycle as the interrupt register's update is also provoked. The bench expects `irq` in that cycle to reflect the old compare, and the new compare one edge later.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_CMP   = 3'd1,
        SEL_TVAL  = 3'd2,
        SEL_OFFS  = 3'd3,
        SEL_COUNT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic en;
    } ctrl_t;

    localparam int CTRL_READ_W = 3;

    function automatic reg_sel_e decode_sel(input logic [2:0] raw);
        reg_sel_e s;
        s = reg_sel_e'(raw);
        return s;
    endfunction

    function automatic logic [CTRL_READ_W-1:0] ctrl_view(input ctrl_t c, input logic st);
        return {st, c.mask, c.en};
    endfunction

endpackage

// File: rtl/cvt_regs.sv
module cvt_regs
    import cvt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int TV_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] vcount,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] offs_q
);
    localparam int EXT_W = CNT_W - TV_W;

    reg_sel_e         sel;
    logic [CNT_W-1:0] tval_ext;
    logic [CNT_W-1:0] cmp_from_tval;

    always_comb begin
        sel           = decode_sel(wr_sel);
        tval_ext      = {{EXT_W{wr_data[TV_W-1]}}, wr_data[TV_W-1:0]};
        cmp_from_tval = vcount + tval_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            offs_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl_q.en   <= wr_data[0];
                    ctrl_q.mask <= wr_data[1];
                end
                SEL_CMP:  cmp_q  <= wr_data;
                SEL_TVAL: cmp_q  <= cmp_from_tval;
                SEL_OFFS: offs_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cvt_cond.sv
module cvt_cond
    import cvt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] phys_count,
    input  logic [CNT_W-1:0] offs,
    input  logic [CNT_W-1:0] cmp,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] vcount,
    output logic             status,
    output logic             irq_q
);
    logic reached;

    always_comb begin
        vcount  = phys_count - offs;
        reached = (vcount >= cmp);
        status  = ctrl.en & reached;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= status & ~ctrl.mask;
    end
endmodule

// File: rtl/cvt_rdmux.sv
module cvt_rdmux
    import cvt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int TV_W  = 32
) (
    input  logic [2:0]       rd_sel,
    input  ctrl_t            ctrl,
    input  logic             status,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] offs,
    input  logic [CNT_W-1:0] vcount,
    output logic [CNT_W-1:0] rd_data
);
    logic [CNT_W-1:0] remain;

    always_comb begin
        remain  = cmp - vcount;
        rd_data = '0;
        case (decode_sel(rd_sel))
            SEL_CTRL:  rd_data[CTRL_READ_W-1:0] = ctrl_view(ctrl, status);
            SEL_CMP:   rd_data = cmp;
            SEL_TVAL:  rd_data[TV_W-1:0] = remain[TV_W-1:0];
            SEL_OFFS:  rd_data = offs;
            SEL_COUNT: rd_data = vcount;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cvt_timer.sv
module cvt_timer
    import cvt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int TV_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] phys_count,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] cmp_w;
    logic [CNT_W-1:0] offs_w;
    logic [CNT_W-1:0] vcount_w;
    logic             status_w;

    cvt_regs #(.CNT_W(CNT_W), .TV_W(TV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .vcount  (vcount_w),
        .ctrl_q  (ctrl_w),
        .cmp_q   (cmp_w),
        .offs_q  (offs_w)
    );

    cvt_cond #(.CNT_W(CNT_W)) u_cond (
        .clk        (clk),
        .rst        (rst),
        .phys_count (phys_count),
        .offs       (offs_w),
        .cmp        (cmp_w),
        .ctrl       (ctrl_w),
        .vcount     (vcount_w),
        .status     (status_w),
        .irq_q      (irq)
    );

    cvt_rdmux #(.CNT_W(CNT_W), .TV_W(TV_W)) u_rdmux (
        .rd_sel  (rd_sel),
        .ctrl    (ctrl_w),
        .status  (status_w),
        .cmp     (cmp_w),
        .offs    (offs_w),
        .vcount  (vcount_w),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/cvt_timer_chk.sv
module cvt_timer_chk #(
    parameter int CNT_W = 64,
    parameter int TV_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             en,
    input logic             mask,
    input logic             status,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] vcount,
    input logic             irq
);
    localparam int EXT_W = CNT_W - TV_W;

    // R1: the edge after reset leaves the interrupt low
    p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !irq);

    // R3: status needs enable and a reached limit
    p_status_reached_r3: assert property (@(posedge clk) disable iff (rst)
        status |-> (en && (vcount >= cmp)));

    // R4: interrupt only follows an enabled, unmasked, reached cycle
    p_irq_gated_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(status && !mask && en));

    // R5: compare holds without a write
    p_cmp_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmp));

    // R7: relative write lands on count plus sign-extended value
    p_tval_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd2) |=>
        cmp == $past(vcount) + {{EXT_W{$past(wr_data[TV_W-1])}}, $past(wr_data[TV_W-1:0])});

    // R3: disabled channel reports no status
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !en |-> !status);
endmodule

bind cvt_timer cvt_timer_chk #(.CNT_W(CNT_W), .TV_W(TV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .en      (ctrl_w.en),
    .mask    (ctrl_w.mask),
    .status  (status_w),
    .cmp     (cmp_w),
    .vcount  (vcount_w),
    .irq     (irq)
);

// File: tb/cvt_timer_bench.sv
`timescale 1ns/1ps
module cvt_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] phys_count = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cvt_timer u_cvt_timer (
        .clk(clk), .rst(rst), .phys_count(phys_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [63:0] phys;
        logic [63:0] off;
        logic [63:0] cmp;
        logic [2:0]  ctrl;
        logic        st;
        logic        irq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{64'd100, 64'd0, 64'd150, 3'd1, 1'b0, 1'b0},
        '{64'd150, 64'd0, 64'd150, 3'd1, 1'b1, 1'b1},
        '{64'd200, 64'd0, 64'd150, 3'd3, 1'b1, 1'b0},
        '{64'd200, 64'd100, 64'd150, 3'd1, 1'b0, 1'b0},
        '{64'd0, 64'd1, 64'd5, 3'd1, 1'b1, 1'b1},
        '{64'd1000, 64'd0, 64'd10, 3'd0, 1'b0, 1'b0},
        '{64'h1_0000_0000, 64'd0, 64'h0_FFFF_FFFF, 3'd1, 1'b1, 1'b1},
        '{64'd7, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [63:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 64'd0);
        rd(3'd1, v); check("R1 cmp", v, 64'd0);
        rd(3'd3, v); check("R1 offs", v, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);

        // table walk: R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            phys_count = VECS[i].phys;
            wr(3'd3, VECS[i].off);
            wr(3'd1, VECS[i].cmp);
            wr(3'd0, {61'd0, VECS[i].ctrl});
            rd(3'd4, v); check("R2 vcount", v, VECS[i].phys - VECS[i].off);
            rd(3'd0, v); check("R3 ctrl/status", v, {61'd0, VECS[i].st, VECS[i].ctrl[1:0]});
            rd(3'd2, v);
            check("R6 tval", v, {32'd0, 32'(VECS[i].cmp - (VECS[i].phys - VECS[i].off))});
            @(posedge clk); #1;
            check("R4 irq", {63'd0, irq}, {63'd0, VECS[i].irq});
        end

        // R7 relative writes
        wr(3'd3, 64'd0);
        phys_count = 64'd1000;
        wr(3'd2, 64'h0000_0000_FFFF_FFF6);
        rd(3'd1, v); check("R7 negative tval", v, 64'd990);
        wr(3'd2, 64'hDEAD_BEEF_0000_0032);
        rd(3'd1, v); check("R7 positive tval", v, 64'd1050);
        rd(3'd2, v); check("R6 tval readback", v, 64'd50);
        phys_count = 64'd1050;
        rd(3'd2, v); check("R6 tval zero", v, 64'd0);
        rd(3'd0, v); check("R3 equal fires", v, 64'd5);

        // same cycle: relative write samples pre-edge count (R7)
        @(negedge clk);
        phys_count = 64'd2000;
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 64'd5;
        @(posedge clk); #1;
        wr_en = 1'b0; phys_count = 64'd2003;
        rd(3'd1, v); check("R7 same-edge count", v, 64'd2005);

        // compare write vs irq update (R4): irq follows old compare one edge
        wr(3'd0, 64'd1);
        phys_count = 64'd100;
        wr(3'd1, 64'd50);
        @(posedge clk); #1;
        check("R4 irq set", {63'd0, irq}, 64'd1);
        wr(3'd1, 64'd500);
        check("R4 irq from old cmp", {63'd0, irq}, 64'd1);
        @(posedge clk); #1;
        check("R4 irq from new cmp", {63'd0, irq}, 64'd0);

        // R8 control writes above bit 1 ignored
        wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3'd0, v); check("R8 ctrl mask", v, 64'd3);
        wr(3'd0, 64'd4);
        rd(3'd0, v); check("R8 status write ignored", v, 64'd0);

        // R9 offset re-evaluates
        wr(3'd0, 64'd1);
        wr(3'd1, 64'd500);
        phys_count = 64'd600;
        wr(3'd3, 64'd200);
        rd(3'd0, v); check("R9 before", v, 64'd1);
        wr(3'd3, 64'd100);
        rd(3'd0, v); check("R9 after", v, 64'd5);
        rd(3'd3, v); check("R9 offs read", v, 64'd100);

        // R10 unused selects
        wr(3'd5, 64'h1234);
        wr(3'd7, 64'h5678);
        rd(3'd6, v); check("R10 read zero", v, 64'd0);
        rd(3'd1, v); check("R10 cmp untouched", v, 64'd500);
        rd(3'd3, v); check("R10 offs untouched", v, 64'd100);
        rd(3'd0, v); check("R10 ctrl untouched", v, 64'd5);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        @(posedge clk); #1;
        check("R1 irq after reset", {63'd0, irq}, 64'd0);
        rd(3'd1, v); check("R1 cmp after reset", v, 64'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule